// File: doc/BRIEF.md
# Buffer Slowdown Ranking Engine

This block runs the on-chip characterization sweep for a ring oscillator whose delay stages are made of many parallel tri-state buffers. It measures the oscillator frequency by counting rising edges of the free-running oscillator over a fixed window of reference clock cycles. The edge counter runs in the oscillator's own domain and reaches the reference domain as a Gray code through a two-flop synchronizer. The sweep first measures the oscillator with every buffer enabled. It then turns off one buffer at a time and measures each of those configurations. Every configuration is measured over several windows, and the window counts are summed.

When the sweep ends, the engine works out how much each buffer slows the oscillator: the baseline count sum minus the buffer's own count sum. It then emits the buffer indices one per write strobe, from the largest slowdown to the smallest. The enable generator that follows uses this list to pick buffers for coarse and fine frequency steps. A done level marks the end of the list.

Top module: `buf_slowdown_ranker`

## Requirements
- R1: After reset, `enMask` is all ones, `done` is 0 and `rankWr` is 0.
- R2: An accepted start runs the configurations in a fixed order. First comes the baseline, with `enMask` all ones. Then buffer 0, 1, ... NUM_BUF-1 is disabled in turn, alone, with `enMask` bit i = 0 meaning buffer i is off. `enMask` never has more than one zero bit, and it returns to all ones after the last configuration.
- R3: After each mask change there is a settling gap of SETTLE_LEN reference cycles. The configuration is then measured over NUM_REP windows. Each window spans exactly WIN_LEN reference cycles and counts the rising edges of `oscIn` in that span. The window counts are summed per configuration.
- R4: The slowdown of buffer i is the baseline sum minus the sum of buffer i. Ranking position 0 holds the buffer with the largest slowdown, and the positions that follow hold smaller or equal slowdowns.
- R5: When slowdowns are equal, the lower buffer index takes the earlier ranking position.
- R6: The ranking is delivered as NUM_BUF one-cycle pulses of `rankWr`, at least NUM_BUF cycles apart. `rankPos` counts 0, 1, ... NUM_BUF-1 and `rankIdx` carries the buffer index for that position.
- R7: `done` rises in the cycle after the write for position NUM_BUF-1. It stays high, with `enMask` all ones, until the next accepted start clears it in the following cycle.
- R8: A start that arrives while a sweep is running has no effect on the sweep, its timing or its results.
- R9: `done` is first seen high (NUM_BUF+1)*(SETTLE_LEN+NUM_REP*(WIN_LEN+1)) + NUM_BUF*NUM_BUF + 1 reference cycles after the clock edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; defines the window length |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| oscIn | input | 1 | Ring oscillator output, asynchronous to refClk |
| start | input | 1 | Begin a sweep; sampled on refClk, accepted only when idle or done |
| enMask | output | NUM_BUF | Buffer enables, bit i = 1 keeps buffer i on |
| rankWr | output | 1 | One-cycle strobe for a ranking entry |
| rankPos | output | $clog2(NUM_BUF) | Ranking position of the entry, 0 = largest slowdown |
| rankIdx | output | $clog2(NUM_BUF) | Buffer index stored at that position |
| done | output | 1 | Ranking complete; held until the next accepted start |

## Verification
The start input can coincide with an open measurement window: a command arrives while the engine is counting edges for some configuration. The bench provokes this by pulsing start several hundred cycles into a sweep, in the middle of a window. It judges the outcome by three things: the cycle in which done rises, the logged sequence of enable masks, and the final ranking. All three must match an undisturbed sweep. The oscillator model uses periods that divide the window exactly, so the window sums, the ties and the 12-bit counter wrap-around are all checked against exact values.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_START,
    ST_RUN,
    ST_SORT,
    ST_FIN,
    ST_DONE
  } bsrState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrAcc;    // clear all sums and the running maximum
    logic winStart;  // capture the synchronized count at window open
    logic winEnd;    // add the window delta to the selected sum
    logic takeBest;  // candidate beats the running maximum
    logic clrBest;   // reset the running maximum for a new pass
  } bsrStrobe_t;

endpackage

// File: rtl/bsr_cnt_sync.sv
module bsr_cnt_sync #(
  parameter int CNT_W = 12
) (
  input  logic             oscIn,
  input  logic             refClk,
  input  logic             rstN,
  output logic [CNT_W-1:0] refCount
);

  logic [CNT_W-1:0] oscBin, oscNext, oscGray;
  logic [CNT_W-1:0] grayMeta, graySync;

  assign oscNext = oscBin + CNT_W'(1);

  // oscillator domain: binary counter plus a registered Gray copy
  always_ff @(posedge oscIn or negedge rstN) begin
    if (!rstN) begin
      oscBin  <= '0;
      oscGray <= '0;
    end else begin
      oscBin  <= oscNext;
      oscGray <= oscNext ^ (oscNext >> 1);
    end
  end

  // reference domain: two-flop synchronizer
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      grayMeta <= '0;
      graySync <= '0;
    end else begin
      grayMeta <= oscGray;
      graySync <= grayMeta;
    end
  end

  function automatic logic [CNT_W-1:0] grayToBin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign refCount = grayToBin(graySync);

endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int CNT_W   = 12,
  parameter int ACC_W   = 19,
  parameter int CFG_W   = 4,
  parameter int IDX_W   = 3
) (
  input  logic             refClk,
  input  logic             rstN,
  input  bsrStrobe_t       strobe,
  input  logic [CFG_W-1:0] cfgSel,
  input  logic [IDX_W-1:0] scanSel,
  input  logic [CNT_W-1:0] refCount,
  output logic             candGreater
);

  localparam logic signed [ACC_W:0] MIN_VAL = {1'b1, {ACC_W{1'b0}}};

  logic [ACC_W-1:0]        accs [NUM_BUF+1];  // entry 0 is the baseline
  logic [CNT_W-1:0]        startCnt;
  logic [CNT_W-1:0]        winDelta;
  logic [CFG_W-1:0]        candSel;
  logic signed [ACC_W:0]   candDiff;
  logic signed [ACC_W:0]   bestVal;

  assign winDelta    = refCount - startCnt;  // modulo the counter width
  assign candSel     = CFG_W'(scanSel) + CFG_W'(1);
  assign candDiff    = $signed({1'b0, accs[0]}) - $signed({1'b0, accs[candSel]});
  assign candGreater = candDiff > bestVal;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      startCnt <= '0;
    end else if (strobe.winStart) begin
      startCnt <= refCount;
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= NUM_BUF; i++) accs[i] <= '0;
    end else if (strobe.clrAcc) begin
      for (int i = 0; i <= NUM_BUF; i++) accs[i] <= '0;
    end else if (strobe.winEnd) begin
      accs[cfgSel] <= accs[cfgSel] + ACC_W'(winDelta);
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      bestVal <= MIN_VAL;
    end else if (strobe.clrAcc || strobe.clrBest) begin
      bestVal <= MIN_VAL;
    end else if (strobe.takeBest) begin
      bestVal <= candDiff;
    end
  end

endmodule

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
#(
  parameter int NUM_BUF    = 8,
  parameter int WIN_LEN    = 64,
  parameter int NUM_REP    = 100,
  parameter int SETTLE_LEN = 4,
  parameter int CFG_W      = 4,
  parameter int IDX_W      = 3
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               start,
  input  logic               candGreater,
  output bsrStrobe_t         strobe,
  output logic [CFG_W-1:0]   cfgSel,
  output logic [IDX_W-1:0]   scanSel,
  output logic [NUM_BUF-1:0] enMask,
  output logic               rankWr,
  output logic [IDX_W-1:0]   rankPos,
  output logic [IDX_W-1:0]   rankIdx,
  output logic               done
);

  localparam int SET_W = $clog2(SETTLE_LEN + 1);
  localparam int WIN_W = $clog2(WIN_LEN + 1);
  localparam int REP_W = $clog2(NUM_REP + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_LEN - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(NUM_REP - 1);
  localparam logic [CFG_W-1:0] CFG_LAST = CFG_W'(NUM_BUF);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BUF - 1);

  bsrState_e          state;
  logic [SET_W-1:0]   settleCnt;
  logic [WIN_W-1:0]   winCnt;
  logic [REP_W-1:0]   repCnt;
  logic [CFG_W-1:0]   cfgIdx;
  logic [IDX_W-1:0]   scanIdx, passIdx, bestIdx, pickIdx;
  logic [NUM_BUF-1:0] picked;
  logic               measuring, winLast, passEnd;

  assign measuring = (state == ST_SETTLE) || (state == ST_START) || (state == ST_RUN);
  assign winLast   = (state == ST_RUN) && (winCnt == WIN_LAST);
  assign passEnd   = (state == ST_SORT) && (scanIdx == IDX_LAST);
  assign cfgSel    = cfgIdx;
  assign scanSel   = scanIdx;
  assign done      = (state == ST_DONE);

  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) enMask[i] = !(measuring && (cfgIdx == CFG_W'(i + 1)));
  end

  always_comb begin
    strobe          = '0;
    strobe.clrAcc   = ((state == ST_IDLE) || (state == ST_DONE)) && start;
    strobe.winStart = (state == ST_START);
    strobe.winEnd   = winLast;
    strobe.takeBest = (state == ST_SORT) && !picked[scanIdx] && candGreater;
    strobe.clrBest  = passEnd;
    pickIdx         = strobe.takeBest ? scanIdx : bestIdx;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      winCnt    <= '0;
      repCnt    <= '0;
      cfgIdx    <= '0;
      scanIdx   <= '0;
      passIdx   <= '0;
      bestIdx   <= '0;
      picked    <= '0;
      rankWr    <= 1'b0;
      rankPos   <= '0;
      rankIdx   <= '0;
    end else begin
      rankWr <= 1'b0;
      unique case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state     <= ST_SETTLE;
          cfgIdx    <= '0;
          settleCnt <= '0;
        end
        ST_SETTLE: begin
          settleCnt <= settleCnt + SET_W'(1);
          if (settleCnt == SET_LAST) begin
            state  <= ST_START;
            repCnt <= '0;
          end
        end
        ST_START: begin
          state  <= ST_RUN;
          winCnt <= '0;
        end
        ST_RUN: begin
          winCnt <= winCnt + WIN_W'(1);
          if (winLast) begin
            if (repCnt != REP_LAST) begin
              repCnt <= repCnt + REP_W'(1);
              state  <= ST_START;
            end else if (cfgIdx == CFG_LAST) begin
              state   <= ST_SORT;
              scanIdx <= '0;
              passIdx <= '0;
              picked  <= '0;
            end else begin
              cfgIdx    <= cfgIdx + CFG_W'(1);
              settleCnt <= '0;
              state     <= ST_SETTLE;
            end
          end
        end
        ST_SORT: begin
          scanIdx <= scanIdx + IDX_W'(1);
          if (strobe.takeBest) bestIdx <= scanIdx;
          if (passEnd) begin
            rankWr          <= 1'b1;
            rankPos         <= passIdx;
            rankIdx         <= pickIdx;
            picked[pickIdx] <= 1'b1;
            scanIdx         <= '0;
            passIdx         <= passIdx + IDX_W'(1);
            if (passIdx == IDX_LAST) state <= ST_FIN;
          end
        end
        ST_FIN:  state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/buf_slowdown_ranker.sv
module buf_slowdown_ranker
  import bsr_pkg::*;
#(
  parameter int NUM_BUF    = 8,
  parameter int CNT_W      = 12,
  parameter int WIN_LEN    = 64,
  parameter int NUM_REP    = 100,
  parameter int SETTLE_LEN = 4,
  localparam int IDX_W     = $clog2(NUM_BUF),
  localparam int CFG_W     = $clog2(NUM_BUF + 1),
  localparam int ACC_W     = CNT_W + $clog2(NUM_REP + 1)
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               oscIn,
  input  logic               start,
  output logic [NUM_BUF-1:0] enMask,
  output logic               rankWr,
  output logic [IDX_W-1:0]   rankPos,
  output logic [IDX_W-1:0]   rankIdx,
  output logic               done
);

  bsrStrobe_t       strobe;
  logic [CFG_W-1:0] cfgSel;
  logic [IDX_W-1:0] scanSel;
  logic [CNT_W-1:0] refCount;
  logic             candGreater;

  bsr_cnt_sync #(.CNT_W(CNT_W)) i_sync (
    .oscIn   (oscIn),
    .refClk  (refClk),
    .rstN    (rstN),
    .refCount(refCount)
  );

  bsr_ctrl #(
    .NUM_BUF(NUM_BUF), .WIN_LEN(WIN_LEN), .NUM_REP(NUM_REP),
    .SETTLE_LEN(SETTLE_LEN), .CFG_W(CFG_W), .IDX_W(IDX_W)
  ) i_ctrl (
    .refClk     (refClk),
    .rstN       (rstN),
    .start      (start),
    .candGreater(candGreater),
    .strobe     (strobe),
    .cfgSel     (cfgSel),
    .scanSel    (scanSel),
    .enMask     (enMask),
    .rankWr     (rankWr),
    .rankPos    (rankPos),
    .rankIdx    (rankIdx),
    .done       (done)
  );

  bsr_datapath #(
    .NUM_BUF(NUM_BUF), .CNT_W(CNT_W), .ACC_W(ACC_W), .CFG_W(CFG_W), .IDX_W(IDX_W)
  ) i_dp (
    .refClk     (refClk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgSel     (cfgSel),
    .scanSel    (scanSel),
    .refCount   (refCount),
    .candGreater(candGreater)
  );

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int NUM_BUF = 8,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input logic               refClk,
  input logic               rstN,
  input logic [NUM_BUF-1:0] enMask,
  input logic               rankWr,
  input logic [IDX_W-1:0]   rankPos,
  input logic               done
);

  localparam logic [IDX_W-1:0] POS_LAST = IDX_W'(NUM_BUF - 1);

  // R2: at most one buffer is off at any time
  a_r2_single_off: assert property (@(posedge refClk) disable iff (!rstN)
    $countones(~enMask) <= 1);

  // R6: ranking strobes are single-cycle pulses
  a_r6_single_pulse: assert property (@(posedge refClk) disable iff (!rstN)
    rankWr |=> !rankWr);

  // R7: the last ranking write is followed by done
  a_r7_done_follows_last: assert property (@(posedge refClk) disable iff (!rstN)
    (rankWr && rankPos == POS_LAST) |=> done);

  // R7: done only rises right after the last write
  a_r7_done_rise_cause: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(done) |-> ($past(rankWr) && $past(rankPos) == POS_LAST));

  // R7: while done, every buffer is on and nothing is written
  a_r7_idle_outputs: assert property (@(posedge refClk) disable iff (!rstN)
    done |-> (&enMask && !rankWr));

endmodule

bind buf_slowdown_ranker bsr_checker #(.NUM_BUF(NUM_BUF)) i_chk (
  .refClk (refClk),
  .rstN   (rstN),
  .enMask (enMask),
  .rankWr (rankWr),
  .rankPos(rankPos),
  .done   (done)
);

// File: tb/test_buf_slowdown_ranker.sv
`timescale 1ps/1ps
module test_buf_slowdown_ranker;

  localparam int N   = 4;
  localparam int W   = 64;
  localparam int R   = 3;
  localparam int S   = 4;
  localparam int LAT = (N + 1) * (S + R * (W + 1)) + N * N + 2;  // posedge count incl. accepting edge
  localparam int WIN_PS = W * 8000;

  logic         refClk = 1'b0;
  logic         rstN   = 1'b0;
  logic         oscIn  = 1'b0;
  logic         start  = 1'b0;
  logic [N-1:0] enMask;
  logic         rankWr;
  logic [1:0]   rankPos, rankIdx;
  logic         done;

  int bufHalf [N];
  int nRun  = 0;
  int nFail = 0;

  buf_slowdown_ranker #(.NUM_BUF(N), .CNT_W(12), .WIN_LEN(W), .NUM_REP(R), .SETTLE_LEN(S))
    i_buf_slowdown_ranker (
      .refClk(refClk), .rstN(rstN), .oscIn(oscIn), .start(start),
      .enMask(enMask), .rankWr(rankWr), .rankPos(rankPos), .rankIdx(rankIdx), .done(done));

  always #4000 refClk = ~refClk;  // 125 MHz

  function automatic int halfFor(input logic [N-1:0] m);
    int h = 500;
    if ($countones(~m) == 1)
      for (int i = 0; i < N; i++) if (!m[i]) h = bufHalf[i];
    return h;
  endfunction

  // oscillator model: toggles land at 50 ps mod 100, never on a refClk edge
  initial begin
    #350;
    forever begin
      #(halfFor(enMask));
      oscIn = ~oscIn;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected ranking from the requirements (R4, R5)
  task automatic expectRank(output int exp [N]);
    int  diff [N];
    bit  used [N];
    for (int i = 0; i < N; i++) begin
      diff[i] = R * (WIN_PS / 1000 - WIN_PS / (2 * bufHalf[i]));
      used[i] = 1'b0;
    end
    for (int p = 0; p < N; p++) begin
      int best = -1;
      for (int i = 0; i < N; i++)
        if (!used[i] && (best < 0 || diff[i] > diff[best])) best = i;
      exp[p]    = best;
      used[best] = 1'b1;
    end
  endtask

  task automatic runSweep(input string req, input int injectAt);
    int          k = 0;
    int          nWr = 0;
    int          nLog = 0;
    bit          orderOk = 1'b1;
    bit          maskOk = 1'b1;
    int          got [N];
    int          exp [N];
    logic [N-1:0] lastMask = '1;
    logic [N-1:0] logM [8];
    expectRank(exp);
    for (int i = 0; i < N; i++) got[i] = -1;
    @(negedge refClk);
    start = 1'b1;
    @(posedge refClk);
    k = 1;
    forever begin
      @(negedge refClk);
      start = (k == injectAt);
      if (k == 1) chk(!done, "R7", "done cleared after start", int'(done), 0);
      if ($countones(~enMask) > 1) maskOk = 1'b0;
      if (enMask != lastMask) begin
        if (nLog < 8) logM[nLog] = enMask;
        nLog++;
        lastMask = enMask;
      end
      if (rankWr) begin
        if (int'(rankPos) != nWr) orderOk = 1'b0;
        got[rankPos] = int'(rankIdx);
        nWr++;
      end
      if (done || k > LAT + 200) break;
      @(posedge refClk);
      k++;
    end
    start = 1'b0;
    chk(done, "R9", {req, " watchdog: sweep finished"}, int'(done), 1);
    chk(k == LAT, "R9", {req, " cycles to done"}, k, LAT);
    chk(orderOk && nWr == N, "R6", {req, " write count/order"}, nWr, N);
    chk(maskOk, "R2", {req, " single buffer off"}, int'(maskOk), 1);
    chk(nLog == N + 1, "R2", {req, " mask changes"}, nLog, N + 1);
    for (int i = 0; i < N && i + 1 <= nLog && i < 8; i++)
      chk(logM[i] == ~(N'(1) << i), "R2", {req, " disabled buffer order"}, int'(logM[i]), int'(~(N'(1) << i)));
    if (nLog == N + 1) chk(logM[N] == '1, "R2", {req, " mask restored"}, int'(logM[N]), int'({N{1'b1}}));
    for (int p = 0; p < N; p++)
      chk(got[p] == exp[p], req, "rank entry", got[p], exp[p]);
    // R7: done held, outputs quiet
    for (int c = 0; c < 5; c++) begin
      @(negedge refClk);
      chk(done && &enMask && !rankWr, "R7", "done held with all buffers on", int'({done, rankWr}), 2);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge refClk);
    chk(enMask == '1, "R1", "enMask at reset", int'(enMask), int'({N{1'b1}}));
    chk(!done, "R1", "done at reset", int'(done), 0);
    chk(!rankWr, "R1", "rankWr at reset", int'(rankWr), 0);
  endtask

  task automatic testDistinct();  // R3 R4: window sums decide the order
    bufHalf = '{1000, 2000, 800, 500};
    runSweep("R4", -1);
  endtask

  task automatic testTies();  // R5: equal slowdowns keep index order
    bufHalf = '{800, 1000, 800, 1000};
    runSweep("R5", -1);
  endtask

  task automatic testAllEqual();  // R5: no buffer has an effect
    bufHalf = '{500, 500, 500, 500};
    runSweep("R5", -1);
  endtask

  task automatic testBusyStart();  // R8: start mid-window is ignored
    bufHalf = '{2000, 500, 1000, 800};
    runSweep("R8", 500);
  endtask

  initial begin
    #(200000 * 8000);
    nFail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge refClk);
    rstN = 1'b1;
    testReset();
    testDistinct();
    testTies();
    testAllEqual();
    testBusyStart();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule